// File: doc/BRIEF.md
# Minimal Harvard Flag-Driven Processor

A small single-issue processor core that fetches 32-bit instruction words from a read-only instruction memory and works on data held in sixteen general-purpose registers. A separate data RAM with its own address, write-data, write-enable and read-data pins serves direct-address loads and stores. Every instruction completes in one clock cycle. Add, subtract, multiply (low half) and five bitwise operations write their result back to a register and refresh four condition flags. Eight conditional jumps test any one flag for set or for clear.

The second operand is either a register or a 16-bit constant taken from the instruction word, so one opcode covers both register and immediate forms. Three data-movement opcodes load a constant, load from a RAM address and store to a RAM address. A halt opcode stops the core. A debug output shows the program counter and whether the core has halted. Both memories are read asynchronously, so an instruction's fetch, operand read, execution and write-back all fall within one clock period.

Top module: `mini_harvard_cpu`

## Requirements
- R1: Instruction word layout: opcode in bits 31:27, destination register in 26:23, first source register in 22:19, immediate-select in bit 18, constant/address in 15:0. The second source register number is bits 3:0 of that field. There are 16 registers, and every arithmetic or logic result is written to the destination register.
- R2: Opcode 0x01 adds, 0x02 subtracts (first minus second) and 0x03 multiplies, keeping the low 16 bits. Carry is the carry-out for add, the borrow (first < second, unsigned) for subtract, and "upper product half non-zero" for multiply. Overflow is signed overflow for add and subtract and is cleared by multiply.
- R3: Opcodes 0x04 AND, 0x05 OR, 0x06 XOR, 0x07 NOT (of the first source) and 0x08 XNOR produce bitwise results and clear carry and overflow.
- R4: After any arithmetic or logic opcode, zero is set exactly when the 16-bit result is 0, and sign equals result bit 15.
- R5: Opcodes 0x10 to 0x17 are conditional jumps. Bits 2:1 pick the flag (0 zero, 1 carry, 2 sign, 3 overflow). Bit 0 = 0 jumps when the flag is set, and bit 0 = 1 jumps when it is clear. A taken jump loads the program counter with bits 7:0 of the constant field.
- R6: When immediate-select is 1, the second operand is the 16-bit constant. When it is 0, the second operand is the register named by bits 3:0.
- R7: Opcode 0x09 writes the constant into the destination. Opcode 0x0A writes RAM[constant] into the destination. Opcode 0x0B writes the first source register into RAM[constant].
- R8: Jumps, the three move/store opcodes, no-operation (0x00) and halt leave all four flags unchanged.
- R9: Apart from a taken jump or halt, the program counter advances by exactly one per instruction.
- R10: Opcode 0x1F halts the core. The program counter freezes at the halt address, the halt output is high, and no further register or RAM write occurs until reset.
- R11: Reset clears the program counter, the flags, the halt state and all sixteen registers to zero.
- R12: Each instruction takes exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 8 | Instruction memory address (program counter) |
| imem_data | input | 32 | Instruction word read at imem_addr |
| dmem_addr | output | 8 | Data RAM address |
| dmem_wdata | output | 16 | Data RAM write data |
| dmem_we | output | 1 | Data RAM write enable |
| dmem_rdata | input | 16 | Data RAM read data at dmem_addr |
| dbg_pc | output | 8 | Current program counter |
| dbg_halted | output | 1 | High once a halt has executed |

## Verification
The bench builds the core with its default widths: 16-bit data, an 8-bit program counter and 8-bit data addresses. This makes the instruction ROM and data RAM models 256 entries each. All eight ALU opcodes are swept over every pair drawn from eight 16-bit corner values (zero, one, the signed extremes, all-ones and mixed patterns). The register and immediate operand forms alternate across the sweep. Each run captures all four flags through both the set and the clear jump variants into RAM. Because the widths are small, every opcode, every flag polarity and every sign and carry boundary can be checked against arithmetic computed in the bench.

// File: rtl/mhc_pkg.sv
package mhc_pkg;

  localparam logic [4:0] OP_NOP  = 5'h00;
  localparam logic [4:0] OP_ADD  = 5'h01;
  localparam logic [4:0] OP_SUB  = 5'h02;
  localparam logic [4:0] OP_MUL  = 5'h03;
  localparam logic [4:0] OP_AND  = 5'h04;
  localparam logic [4:0] OP_OR   = 5'h05;
  localparam logic [4:0] OP_XOR  = 5'h06;
  localparam logic [4:0] OP_NOT  = 5'h07;
  localparam logic [4:0] OP_XNOR = 5'h08;
  localparam logic [4:0] OP_LDI  = 5'h09;
  localparam logic [4:0] OP_LD   = 5'h0A;
  localparam logic [4:0] OP_ST   = 5'h0B;
  localparam logic [4:0] OP_HALT = 5'h1F;

  // jump opcodes are 5'b10_ffp : ff selects the flag, p=1 means "if clear"
  localparam logic [1:0] JMP_CLASS = 2'b10;

  // bit 0 = zero, 1 = carry, 2 = sign, 3 = overflow
  typedef struct packed {
    logic v;
    logic s;
    logic c;
    logic z;
  } flags_t;

  function automatic logic flag_at(input flags_t f, input logic [1:0] idx);
    logic [3:0] bits;
    bits = f;
    return bits[idx];
  endfunction

endpackage

// File: rtl/mhc_regfile.sv
module mhc_regfile #(
  parameter int NREG   = 16,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [DATA_W-1:0]       rdata_a,
  output logic [DATA_W-1:0]       rdata_b
);
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/mhc_alu.sv
module mhc_alu
  import mhc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output flags_t            fl,
  output logic              hit
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W:0]   sum_w;
  logic [DATA_W:0]   dif_w;
  logic [PROD_W-1:0] prod_w;
  logic              cy;
  logic              ov;

  assign sum_w  = {1'b0, a} + {1'b0, b};
  assign dif_w  = {1'b0, a} - {1'b0, b};
  assign prod_w = PROD_W'(a) * PROD_W'(b);

  always_comb begin
    res = '0;
    hit = 1'b1;
    cy  = 1'b0;
    ov  = 1'b0;
    case (op)
      OP_ADD: begin
        res = sum_w[MSB:0];
        cy  = sum_w[DATA_W];
        ov  = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res = dif_w[MSB:0];
        cy  = dif_w[DATA_W];
        ov  = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
      end
      OP_MUL: begin
        res = prod_w[MSB:0];
        cy  = |prod_w[PROD_W-1:DATA_W];
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_XNOR: res = ~(a ^ b);
      default: hit = 1'b0;
    endcase
    fl.z = (res == '0);
    fl.s = res[MSB];
    fl.c = cy;
    fl.v = ov;
  end

  // bitwise group must leave carry and overflow low (R3)
  always_comb begin
    if (hit && (op >= OP_AND) && (op <= OP_XNOR)) begin
      p_logic_clears_cv_r3: assert (!fl.c && !fl.v);
    end
  end

endmodule

// File: rtl/mhc_branch.sv
module mhc_branch
  import mhc_pkg::*;
(
  input  logic [4:0] op,
  input  flags_t     fl,
  output logic       is_jump,
  output logic       take
);
  assign is_jump = (op[4:3] == JMP_CLASS);
  assign take    = is_jump && (flag_at(fl, op[2:1]) ^ op[0]);
endmodule

// File: rtl/mini_harvard_cpu.sv
module mini_harvard_cpu
  import mhc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_W    = 8,
  parameter int DADDR_W = 8,
  parameter int NREG    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [31:0]        imem_data,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic [PC_W-1:0]    dbg_pc,
  output logic               dbg_halted
);
  localparam int RA_W  = $clog2(NREG);
  localparam int IMM_W = 16;

  // reset: asserted at once, released through two flops
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // instruction fields
  logic [4:0]       op;
  logic [RA_W-1:0]  rd, rs1, rs2;
  logic             isel;
  logic [IMM_W-1:0] imm;
  logic [1:0]       unused_bits;

  assign op          = imem_data[31:27];
  assign rd          = imem_data[23 +: RA_W];
  assign rs1         = imem_data[19 +: RA_W];
  assign isel        = imem_data[18];
  assign unused_bits = imem_data[17:16];
  assign imm         = imem_data[15:0];
  assign rs2         = imm[RA_W-1:0];

  // state
  logic [PC_W-1:0] pc_q, pc_d;
  flags_t          flags_q, flags_d;
  logic            halt_q, halt_d;
  logic            pc_en, flags_en;

  // datapath
  logic [DATA_W-1:0] opa, rdata_b, opb, alu_res, wb_data;
  flags_t            alu_fl;
  logic              alu_hit, is_jump, take, run;
  logic              is_ldi, is_ld, is_st, is_halt, rf_we;

  assign run     = !halt_q;
  assign is_ldi  = (op == OP_LDI);
  assign is_ld   = (op == OP_LD);
  assign is_st   = (op == OP_ST);
  assign is_halt = (op == OP_HALT);
  assign opb     = isel ? DATA_W'(imm) : rdata_b;

  mhc_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (rf_we),
    .waddr   (rd),
    .wdata   (wb_data),
    .raddr_a (rs1),
    .raddr_b (rs2),
    .rdata_a (opa),
    .rdata_b (rdata_b)
  );

  mhc_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (op),
    .a   (opa),
    .b   (opb),
    .res (alu_res),
    .fl  (alu_fl),
    .hit (alu_hit)
  );

  mhc_branch u_br (
    .op      (op),
    .fl      (flags_q),
    .is_jump (is_jump),
    .take    (take)
  );

  // write-back and memory side
  always_comb begin
    if (alu_hit)     wb_data = alu_res;
    else if (is_ldi) wb_data = DATA_W'(imm);
    else             wb_data = dmem_rdata;
  end
  assign rf_we      = run && (alu_hit || is_ldi || is_ld);
  assign dmem_addr  = imm[DADDR_W-1:0];
  assign dmem_wdata = opa;
  assign dmem_we    = run && is_st;

  // next state
  always_comb begin
    pc_en    = run && !is_halt;
    pc_d     = take ? imm[PC_W-1:0] : pc_q + 1'b1;
    flags_en = run && alu_hit;
    flags_d  = alu_fl;
    halt_d   = run && is_halt;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pc_q    <= '0;
      flags_q <= '0;
      halt_q  <= 1'b0;
    end else begin
      if (pc_en)    pc_q    <= pc_d;
      if (flags_en) flags_q <= flags_d;
      if (halt_d)   halt_q  <= 1'b1;
    end
  end

  assign imem_addr  = pc_q;
  assign dbg_pc     = pc_q;
  assign dbg_halted = halt_q;

  // sequential step when nothing redirects the fetch (R9, R12)
  p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (run && !take && !is_halt) |=> (pc_q == $past(pc_q) + 1'b1));

  // taken jump lands on the constant (R5)
  p_jump_target_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (run && take) |=> (pc_q == $past(imm[PC_W-1:0])));

  // halted core holds its address and state (R10)
  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_q)
    halt_q |=> (halt_q && $stable(pc_q)));

  p_halt_no_write_r10: assert property (@(posedge clk) disable iff (!rst_q)
    halt_q |-> (!dmem_we && !rf_we));

  // non-ALU instructions keep the flags (R8)
  p_flags_keep_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (!alu_hit) |=> $stable(flags_q));

endmodule

// File: tb/test_mini_harvard_cpu.sv
module test_mini_harvard_cpu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [31:0] imem_data;
  logic [7:0]  dmem_addr;
  logic [15:0] dmem_wdata;
  logic        dmem_we;
  logic [15:0] dmem_rdata;
  logic [7:0]  dbg_pc;
  logic        dbg_halted;

  always #5 clk = ~clk;

  mini_harvard_cpu i_mini_harvard_cpu (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .dbg_pc     (dbg_pc),
    .dbg_halted (dbg_halted)
  );

  logic [31:0] rom [256];
  logic [15:0] ram [256];
  int          n_writes = 0;

  assign imem_data  = rom[imem_addr];
  assign dmem_rdata = ram[dmem_addr];

  always @(posedge clk) begin
    if (dmem_we) begin
      ram[dmem_addr] <= dmem_wdata;
      n_writes <= n_writes + 1;
    end
  end

  int errors = 0;
  int checks = 0;

  localparam logic [4:0] C_NOP = 5'h00, C_ADD = 5'h01, C_SUB = 5'h02, C_MUL = 5'h03;
  localparam logic [4:0] C_AND = 5'h04, C_OR = 5'h05, C_XOR = 5'h06, C_NOT = 5'h07;
  localparam logic [4:0] C_XNOR = 5'h08, C_LDI = 5'h09, C_LD = 5'h0A, C_ST = 5'h0B;
  localparam logic [4:0] C_HALT = 5'h1F;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] op, input logic [3:0] rd,
                                      input logic [3:0] rs1, input logic isel,
                                      input logic [15:0] imm);
    return {op, rd, rs1, isel, 2'b00, imm};
  endfunction

  // returns {v, s, c, z, result}
  function automatic logic [19:0] model(input logic [4:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    logic [16:0] w;
    logic [31:0] p;
    logic [15:0] r;
    logic        c, v;
    c = 1'b0; v = 1'b0; r = '0;
    case (op)
      C_ADD: begin
        w = {1'b0, a} + {1'b0, b}; r = w[15:0]; c = w[16];
        v = (a[15] == b[15]) && (r[15] != a[15]);
      end
      C_SUB: begin
        r = a - b; c = (a < b);
        v = (a[15] != b[15]) && (r[15] != a[15]);
      end
      C_MUL: begin
        p = {16'h0, a} * {16'h0, b}; r = p[15:0]; c = (p[31:16] != 0);
      end
      C_AND:  r = a & b;
      C_OR:   r = a | b;
      C_XOR:  r = a ^ b;
      C_NOT:  r = ~a;
      default: r = ~(a ^ b);
    endcase
    return {v, r[15], c, (r == 16'h0), r};
  endfunction

  task automatic clear_mems();
    for (int i = 0; i < 256; i++) begin
      rom[i] = enc(C_HALT, 4'd0, 4'd0, 1'b0, 16'h0);
      ram[i] = 16'hDEAD;
    end
  endtask

  // flag capture block: set variant into 0x20+f, clear variant into 0x28+f
  // needs r5 = 1 and r6 = 0
  task automatic emit_flags(inout int pc);
    for (int f = 0; f < 4; f++) begin
      rom[pc]     = enc(C_ST, 4'd0, 4'd5, 1'b0, 16'(8'h20 + f));
      rom[pc + 1] = enc(5'h10 | 5'(f << 1), 4'd0, 4'd0, 1'b0, 16'(pc + 3));
      rom[pc + 2] = enc(C_ST, 4'd0, 4'd6, 1'b0, 16'(8'h20 + f));
      rom[pc + 3] = enc(C_ST, 4'd0, 4'd6, 1'b0, 16'(8'h28 + f));
      rom[pc + 4] = enc(5'h11 | 5'(f << 1), 4'd0, 4'd0, 1'b0, 16'(pc + 6));
      rom[pc + 5] = enc(C_ST, 4'd0, 4'd5, 1'b0, 16'(8'h28 + f));
      pc += 6;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string tag);
    int n;
    n = 0;
    while (!dbg_halted && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " halt reached R10"}, 32'(dbg_halted), 32'd1);
  endtask

  task automatic check_flags(input string tag, input logic [3:0] exp, input bit is_logic);
    string nm [4];
    nm[0] = "zero R4"; nm[1] = is_logic ? "carry R3" : "carry R2";
    nm[2] = "sign R4"; nm[3] = is_logic ? "ovf R3" : "ovf R2";
    for (int f = 0; f < 4; f++) begin
      chk($sformatf("%s %s jump-if-set R5 R8", tag, nm[f]), 32'(ram[8'h20 + f]), 32'(exp[f]));
      chk($sformatf("%s %s jump-if-clear R5 R8", tag, nm[f]), 32'(ram[8'h28 + f]), 32'(exp[f]));
    end
  endtask

  logic [15:0] vals [8];
  logic [4:0]  ops [8];

  initial begin
    rst_n = 1'b0;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'h00FF; vals[7] = 16'h0100;
    ops[0] = C_ADD; ops[1] = C_SUB; ops[2] = C_MUL; ops[3] = C_AND;
    ops[4] = C_OR;  ops[5] = C_XOR; ops[6] = C_NOT; ops[7] = C_XNOR;

    // ---- reset state, untouched registers and flags (R11) ----
    clear_mems();
    begin
      int pc;
      pc = 0;
      rom[pc++] = enc(C_LDI, 4'd5, 4'd0, 1'b0, 16'h0001);
      rom[pc++] = enc(C_LDI, 4'd6, 4'd0, 1'b0, 16'h0000);
      emit_flags(pc);
      rom[pc++] = enc(C_ST, 4'd0, 4'd9, 1'b0, 16'h0030);
      rom[pc++] = enc(C_ST, 4'd0, 4'd15, 1'b0, 16'h0031);
    end
    @(negedge clk);
    @(negedge clk);
    chk("reset pc R11", 32'(dbg_pc), 32'd0);
    chk("reset halt R11", 32'(dbg_halted), 32'd0);
    chk("reset no store R11", 32'(dmem_we), 32'd0);
    do_reset();
    wait_halt("reset prog");
    check_flags("after reset R11", 4'b0000, 1'b0);
    chk("reset r9 zero R11", 32'(ram[8'h30]), 32'd0);
    chk("reset r15 zero R11", 32'(ram[8'h31]), 32'd0);

    // ---- LD/LDI/ST, step-by-one, one cycle each, halt (R7 R9 R10 R12) ----
    clear_mems();
    ram[8'h40] = 16'hBEEF;
    for (int i = 0; i < 5; i++) rom[i] = enc(C_NOP, 4'd0, 4'd0, 1'b0, 16'h0);
    rom[5] = enc(C_LD,  4'd7, 4'd0, 1'b0, 16'h0040);
    rom[6] = enc(C_ST,  4'd0, 4'd7, 1'b0, 16'h0041);
    rom[7] = enc(C_LDI, 4'd8, 4'd0, 1'b0, 16'h1357);
    rom[8] = enc(C_ST,  4'd0, 4'd8, 1'b0, 16'h0042);
    rom[9] = enc(C_HALT, 4'd0, 4'd0, 1'b0, 16'h0);
    rom[10] = enc(C_ST, 4'd0, 4'd8, 1'b0, 16'h0043);
    do_reset();
    begin
      logic [7:0] prev;
      int         step_err, t1, t9, n;
      prev = 8'd0; step_err = 0; t1 = -1; t9 = -1; n = 0;
      while (!dbg_halted && n < 100) begin
        @(negedge clk);
        n++;
        if (dbg_pc != prev) begin
          if (dbg_pc != prev + 8'd1) step_err++;
          if (dbg_pc == 8'd1) t1 = n;
          if (dbg_pc == 8'd9) t9 = n;
          prev = dbg_pc;
        end
      end
      chk("pc steps by one R9", 32'(step_err), 32'd0);
      chk("one cycle per instruction R12", 32'(t9 - t1), 32'd8);
    end
    chk("LD then ST direct R7", 32'(ram[8'h41]), 32'h0000BEEF);
    chk("LDI then ST R7", 32'(ram[8'h42]), 32'h00001357);
    begin
      int wr0;
      wr0 = n_writes;
      repeat (10) @(negedge clk);
      chk("halt pc frozen R10", 32'(dbg_pc), 32'd9);
      chk("halt output held R10", 32'(dbg_halted), 32'd1);
      chk("no writes after halt R10", 32'(n_writes - wr0), 32'd0);
      chk("instruction past halt not run R10", 32'(ram[8'h43]), 32'h0000DEAD);
    end

    // ---- ALU sweep: every op over all operand pairs (R1..R6, R8) ----
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic        im;
          logic [19:0] e;
          int          pc;
          string       tag;
          im = 1'((i + j) % 2);
          e  = model(ops[k], vals[i], vals[j]);
          clear_mems();
          pc = 0;
          rom[pc++] = enc(C_LDI, 4'd1, 4'd0, 1'b0, vals[i]);
          rom[pc++] = enc(C_LDI, 4'd2, 4'd0, 1'b0, vals[j]);
          rom[pc++] = enc(ops[k], 4'd3, 4'd1, im, im ? vals[j] : 16'h0002);
          rom[pc++] = enc(C_ST, 4'd0, 4'd3, 1'b0, 16'h0010);
          rom[pc++] = enc(C_LDI, 4'd5, 4'd0, 1'b0, 16'h0001);
          rom[pc++] = enc(C_LDI, 4'd6, 4'd0, 1'b0, 16'h0000);
          emit_flags(pc);
          do_reset();
          tag = $sformatf("op=%0h a=%h b=%h %s", ops[k], vals[i], vals[j],
                          im ? "imm R6" : "reg R6");
          wait_halt(tag);
          chk({tag, (k < 3) ? " result R1 R2" : " result R1 R3"},
              32'(ram[8'h10]), 32'(e[15:0]));
          check_flags(tag, e[19:16], k >= 3);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired R12 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule